// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register Window

This block is the register front end of an I/O interrupt controller. Software reaches every internal register through two bus locations: a select register that holds an 8-bit register number, and a window through which the chosen register is read or written. The internal registers are a 4-bit controller ID, a read-only version word, an arbitration word that mirrors the ID, and a table of 64-bit redirection entries, one per interrupt pin. Each entry is reached as two 32-bit halves. An odd select value picks the upper half and an even select value picks the lower half.

The fields of each entry that the delivery logic needs are sent out as flat vectors: mask, trigger mode, vector, destination and delivery mode. The delivery logic drives three per-pin inputs. One sets the remote-IRR bit, one clears it, and one gives the delivery-status level. Software writes cannot change these two status bits. When an entry ends a write in edge mode, its remote-IRR bit is cleared. When a write flips an entry's mask bit, the block sends a one-cycle pulse carrying that pin's number, so the delivery logic can look at the pin again.

The bus side is a plain word slave that never stalls: every strobe is accepted in the cycle it is seen. There is no ready signal and there is no back-pressure. Read data comes back one cycle later, qualified by its own valid pulse.

Top module: `irq_regwin`

## Requirements
- R1: Bus offset 0x00 is the select register. A write there keeps only bits 7:0 of the write data, and a read there returns the stored byte zero-extended.
- R2: With select = 0x01, a window read returns (pin count − 1) in bits 23:16 and the version code (default 0x11) in bits 7:0, with all other bits 0. Window writes to it change nothing.
- R3: With select = 0x00, a window write stores bits 27:24 of the data as the ID, and a window read returns the ID in bits 27:24 with all other bits 0. With select = 0x02, a window read returns the same word, and window writes are ignored.
- R4: When select ≥ 0x10, entry index = (select − 0x10) >> 1. An even select value reaches entry bits 31:0, an odd value reaches bits 63:32, and the window reads back what was written, except for the status bits.
- R5: With select in 0x03–0x0F, or with an entry index ≥ the pin count, a window read returns 0xFFFFFFFF and a window write changes nothing. In particular, no mask changes and no pulse is sent.
- R6: A window write never changes remote-IRR (entry bit 14) or delivery status (entry bit 12). Bit 12 always reads the delivery-status input, registered one cycle.
- R7: When an entry's trigger bit (bit 15, 1 = level, 0 = edge) is 0 after a write, remote-IRR reads 0. A remote-IRR set pulse has no effect on an edge-mode entry. On a level-mode entry, a set pulse makes it 1 and a clear pulse makes it 0.
- R8: After reset, every entry reads with only its mask bit (bit 16) set, and the select and ID registers are 0.
- R9: A window write that flips an entry's mask bit raises mchg_valid for one cycle, in the cycle after the write, with mchg_pin equal to the entry index. A write that leaves the mask unchanged raises no pulse.
- R10: Bus offsets other than 0x00 and 0x10 read as 0, and writes to them change no state.
- R11: The exported fields of each entry are vector = bits 7:0, delivery mode = bits 10:8, trigger = bit 15, mask = bit 16 and destination = bits 63:56. Each export changes in the cycle after the write that sets it.
- R12: Read data appears on bus_rdata with bus_rvalid high for exactly one cycle, in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid pulse |
| rirr_set | input | NUM_PINS | Per-pin remote-IRR set pulse |
| rirr_clr | input | NUM_PINS | Per-pin remote-IRR clear pulse |
| dstat | input | NUM_PINS | Per-pin delivery-status level |
| mask_o | output | NUM_PINS | Mask bit of each entry |
| trig_o | output | NUM_PINS | Trigger bit of each entry |
| vec_o | output | NUM_PINS*8 | Vector of each entry |
| dest_o | output | NUM_PINS*8 | Destination of each entry |
| dmode_o | output | NUM_PINS*3 | Delivery mode of each entry |
| mchg_valid | output | 1 | Mask-change pulse |
| mchg_pin | output | $clog2(NUM_PINS) | Pin index of the mask change |

## Verification
Reads complete one cycle after the strobe. The bench queues the expected word when it issues a read, and a monitor compares against it on the falling edge at which bus_rvalid is high. A pulse with an empty queue counts as a miscompare. Writes take effect at the strobe's rising edge. The mask-change pulse and the exported fields are therefore sampled on the falling edge right after that edge, and the pulse is checked again one cycle later to confirm it has dropped. Status-input pulses are held for exactly one cycle before the entry is read back through the window.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam logic [7:0] OFS_SEL = 8'h00;
  localparam logic [7:0] OFS_WIN = 8'h10;

  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  localparam int F_VEC   = 0;
  localparam int F_DM    = 8;
  localparam int F_DSTAT = 12;
  localparam int F_RIRR  = 14;
  localparam int F_TRIG  = 15;
  localparam int F_MASK  = 16;
  localparam int F_DEST  = 56;

  localparam logic [63:0] ENT_RESET = 64'd1 << F_MASK;
endpackage

// File: rtl/irqw_seldec.sv
module irqw_seldec
  import irqw_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [7:0]    sel_q,
  output logic [3:0]    id_q,
  output logic          win_wr,
  output logic          tbl_hit,
  output logic [IW-1:0] tbl_idx,
  output logic          tbl_hi
);
  logic [7:0] raw_idx;

  assign win_wr  = bus_valid && bus_wr && (bus_addr == OFS_WIN);
  assign raw_idx = (sel_q - SEL_TBL) >> 1;
  assign tbl_hit = (sel_q >= SEL_TBL) && (int'(raw_idx) < NUM_PINS);
  assign tbl_idx = raw_idx[IW-1:0];
  assign tbl_hi  = sel_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
      id_q  <= 4'h0;
    end else begin
      if (bus_valid && bus_wr && bus_addr == OFS_SEL) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == SEL_ID) id_q <= bus_wdata[27:24];
    end
  end

  assert_sel_low_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_wr && bus_addr == OFS_SEL) |=> sel_q == $past(bus_wdata[7:0]));

  assert_id_only_via_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_wr && sel_q == SEL_ID) |=> id_q == $past(id_q));
endmodule

// File: rtl/irqw_entry.sv
module irqw_entry
  import irqw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_lo,
  input  logic        we_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        rirr_clr,
  input  logic        dstat,
  output logic [63:0] q,
  output logic        mask_flip
);
  logic [63:0] ent_q;
  logic [63:0] nxt;
  logic        ds_q;

  always_comb begin
    nxt = ent_q;
    if (we_lo) nxt[31:0] = wdata;
    if (we_hi) nxt[63:32] = wdata;
    nxt[F_RIRR]  = ent_q[F_RIRR];
    nxt[F_DSTAT] = 1'b0;
    if (!nxt[F_TRIG]) nxt[F_RIRR] = 1'b0;
  end

  assign mask_flip = we_lo && (wdata[F_MASK] != ent_q[F_MASK]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= ENT_RESET;
      ds_q  <= 1'b0;
    end else begin
      ds_q <= dstat;
      if (we_lo || we_hi)             ent_q <= nxt;
      else if (rirr_clr)              ent_q[F_RIRR] <= 1'b0;
      else if (rirr_set && ent_q[F_TRIG]) ent_q[F_RIRR] <= 1'b1;
    end
  end

  always_comb begin
    q = ent_q;
    q[F_DSTAT] = ds_q;
  end

  assert_edge_no_rirr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !q[F_TRIG] |-> !q[F_RIRR]);

  assert_write_keeps_rirr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_hi || (we_lo && wdata[F_TRIG])) |=> q[F_RIRR] == $past(q[F_RIRR]));

  assert_status_follows_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lo || we_hi) |=> q[F_DSTAT] == $past(dstat));
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irqw_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_valid,
  input  logic                  bus_wr,
  input  logic [7:0]            bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  input  logic [NUM_PINS-1:0]   rirr_set,
  input  logic [NUM_PINS-1:0]   rirr_clr,
  input  logic [NUM_PINS-1:0]   dstat,
  output logic [NUM_PINS-1:0]   mask_o,
  output logic [NUM_PINS-1:0]   trig_o,
  output logic [NUM_PINS*8-1:0] vec_o,
  output logic [NUM_PINS*8-1:0] dest_o,
  output logic [NUM_PINS*3-1:0] dmode_o,
  output logic                  mchg_valid,
  output logic [IW-1:0]         mchg_pin
);
  localparam logic [7:0]  LAST_PIN = 8'(NUM_PINS - 1);
  localparam logic [31:0] VER_WORD = {8'h00, LAST_PIN, 8'h00, VER_CODE};

  logic [7:0]          sel_q;
  logic [3:0]          id_q;
  logic                win_wr;
  logic                tbl_hit;
  logic [IW-1:0]       tbl_idx;
  logic                tbl_hi;
  logic [63:0]         ent [NUM_PINS];
  logic [NUM_PINS-1:0] flips;
  logic [31:0]         rd_nxt;
  logic                any_flip;
  logic [IW-1:0]       flip_idx;

  irqw_seldec #(.NUM_PINS(NUM_PINS), .IW(IW)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sel_q(sel_q), .id_q(id_q),
    .win_wr(win_wr), .tbl_hit(tbl_hit), .tbl_idx(tbl_idx), .tbl_hi(tbl_hi)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit_i;
    assign hit_i = win_wr && tbl_hit && (int'(tbl_idx) == i);
    irqw_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .we_lo(hit_i && !tbl_hi), .we_hi(hit_i && tbl_hi),
      .wdata(bus_wdata), .rirr_set(rirr_set[i]), .rirr_clr(rirr_clr[i]),
      .dstat(dstat[i]), .q(ent[i]), .mask_flip(flips[i])
    );
    assign mask_o[i]         = ent[i][F_MASK];
    assign trig_o[i]         = ent[i][F_TRIG];
    assign vec_o[i*8 +: 8]   = ent[i][F_VEC +: 8];
    assign dest_o[i*8 +: 8]  = ent[i][F_DEST +: 8];
    assign dmode_o[i*3 +: 3] = ent[i][F_DM +: 3];
  end

  always_comb begin
    any_flip = 1'b0;
    flip_idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (flips[i]) begin
        any_flip = 1'b1;
        flip_idx = IW'(i);
      end
    end
  end

  always_comb begin
    rd_nxt = 32'h0;
    if (bus_addr == OFS_SEL) begin
      rd_nxt = {24'h0, sel_q};
    end else if (bus_addr == OFS_WIN) begin
      if (sel_q == SEL_ID || sel_q == SEL_ARB) rd_nxt = {4'h0, id_q, 24'h0};
      else if (sel_q == SEL_VER)               rd_nxt = VER_WORD;
      else if (tbl_hit)                        rd_nxt = tbl_hi ? ent[tbl_idx][63:32] : ent[tbl_idx][31:0];
      else                                     rd_nxt = 32'hFFFF_FFFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= 32'h0;
      bus_rvalid <= 1'b0;
      mchg_valid <= 1'b0;
      mchg_pin   <= '0;
    end else begin
      bus_rvalid <= bus_valid && !bus_wr;
      if (bus_valid && !bus_wr) bus_rdata <= rd_nxt;
      mchg_valid <= any_flip;
      if (any_flip) mchg_pin <= flip_idx;
    end
  end

  assert_flip_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flips));

  assert_pulse_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mchg_valid |-> $past(bus_valid && bus_wr && bus_addr == OFS_WIN));

  assert_rvalid_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_wr));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_wr && tbl_hit) |=> mask_o == $past(mask_o));
endmodule

// File: tb/sim_irq_regwin.sv
module sim_irq_regwin;
  localparam int NP = 24;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NP-1:0] rirr_set = '0, rirr_clr = '0, dstat = '0;
  logic [NP-1:0] mask_o, trig_o;
  logic [NP*8-1:0] vec_o, dest_o;
  logic [NP*3-1:0] dmode_o;
  logic mchg_valid;
  logic [IW-1:0] mchg_pin;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  irq_regwin #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rirr_set(rirr_set), .rirr_clr(rirr_clr),
    .dstat(dstat), .mask_o(mask_o), .trig_o(trig_o), .vec_o(vec_o),
    .dest_o(dest_o), .dmode_o(dmode_o), .mchg_valid(mchg_valid), .mchg_pin(mchg_pin)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when read data is due
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) chk("R12 unexpected rvalid", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic pulse_status(int pin, bit set);
    @(negedge clk);
    if (set) rirr_set[pin] = 1'b1; else rirr_clr[pin] = 1'b1;
    @(negedge clk);
    rirr_set = '0; rirr_clr = '0;
  endtask

  task automatic chk_pulse(string tag, bit v, int pin);
    chk({tag, " pulse"}, {31'h0, mchg_valid}, {31'h0, v});
    if (v) chk({tag, " pin"}, {27'h0, mchg_pin}, pin[31:0]);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NP-1:0] m_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 mask after reset", {8'h0, mask_o}, {8'h0, {NP{1'b1}}});
    chk_pulse("R9 idle", 1'b0, 0);
    rd(8'h00, 32'h0, "R8 select reset");
    rd(8'h10, 32'h0, "R8 id reset");
    wr(8'h00, 8'h3E);
    rd(8'h10, 32'h0001_0000, "R8 entry23 lo reset");
    wr(8'h00, 8'h3F);
    rd(8'h10, 32'h0, "R8 entry23 hi reset");
    // R1 select
    wr(8'h00, 32'h0000_01AB);
    rd(8'h00, 32'h0000_00AB, "R1 select low byte");
    // R2 version
    wr(8'h00, 32'h1);
    rd(8'h10, 32'h0017_0011, "R2 version");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0017_0011, "R2 version write ignored");
    // R3 id / arb
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hF500_0000);
    rd(8'h10, 32'h0500_0000, "R3 id");
    wr(8'h00, 32'h2);
    rd(8'h10, 32'h0500_0000, "R3 arb mirrors id");
    wr(8'h10, 32'h0A00_0000);
    wr(8'h00, 32'h0);
    rd(8'h10, 32'h0500_0000, "R3 arb write ignored");
    // R4 / R9 / R11 entry 3
    wr(8'h00, 32'h16);
    wr(8'h10, 32'h0000_A531);
    chk_pulse("R9 unmask pin3", 1'b1, 3);
    @(negedge clk);
    chk_pulse("R9 one cycle", 1'b0, 0);
    wr(8'h00, 32'h17);
    wr(8'h10, 32'h5A00_0000);
    chk_pulse("R9 no flip on hi write", 1'b0, 0);
    chk("R11 vector", {24'h0, vec_o[3*8 +: 8]}, 32'h31);
    chk("R11 dmode", {29'h0, dmode_o[3*3 +: 3]}, 32'h5);
    chk("R11 trigger", {31'h0, trig_o[3]}, 32'h1);
    chk("R11 mask", {31'h0, mask_o[3]}, 32'h0);
    chk("R11 dest", {24'h0, dest_o[3*8 +: 8]}, 32'h5A);
    rd(8'h10, 32'h5A00_0000, "R4 odd select high half");
    wr(8'h00, 32'h16);
    rd(8'h10, 32'h0000_A531, "R4 even select low half");
    // R6 / R7 status bits
    pulse_status(3, 1'b1);
    rd(8'h10, 32'h0000_E531, "R7 level set pulse");
    wr(8'h10, 32'h0000_A532);
    rd(8'h10, 32'h0000_E532, "R6 write keeps rirr");
    wr(8'h10, 32'h0000_D033);
    rd(8'h10, 32'h0000_C033, "R6 write keeps status bits");
    @(negedge clk); dstat[3] = 1'b1;
    @(negedge clk);
    rd(8'h10, 32'h0000_D033, "R6 delivery status from input");
    dstat[3] = 1'b0;
    wr(8'h10, 32'h0000_4034);
    rd(8'h10, 32'h0000_0034, "R7 edge clears rirr");
    pulse_status(3, 1'b1);
    rd(8'h10, 32'h0000_0034, "R7 set ignored on edge");
    wr(8'h10, 32'h0000_8034);
    pulse_status(3, 1'b1);
    rd(8'h10, 32'h0000_C034, "R7 set on level");
    pulse_status(3, 1'b0);
    rd(8'h10, 32'h0000_8034, "R7 clear pulse");
    wr(8'h10, 32'h0001_8034);
    chk_pulse("R9 mask pin3", 1'b1, 3);
    wr(8'h00, 32'h10);
    wr(8'h10, 32'h0000_0020);
    chk_pulse("R9 unmask pin0", 1'b1, 0);
    // R5 out of range
    m_before = mask_o;
    wr(8'h00, 32'h40);
    rd(8'h10, 32'hFFFF_FFFF, "R5 index past pins");
    wr(8'h10, 32'h0);
    chk_pulse("R5 no pulse", 1'b0, 0);
    chk("R5 masks unchanged", {8'h0, mask_o}, {8'h0, m_before});
    wr(8'h00, 32'h05);
    rd(8'h10, 32'hFFFF_FFFF, "R5 gap select");
    wr(8'h10, 32'h0);
    chk("R5 gap write no effect", {8'h0, mask_o}, {8'h0, m_before});
    // R10 other offsets
    rd(8'h20, 32'h0, "R10 other offset reads 0");
    wr(8'h20, 32'h77);
    rd(8'h00, 32'h05, "R10 write ignored");
    rd(8'h04, 32'h0, "R10 offset 4");
    repeat (3) @(negedge clk);
    chk("R12 scoreboard drained", exp_q.size(), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule